// File: doc/BRIEF.md
# DMA-Snooping Decompression Stream Gate

This block sits beside the cartridge ROM read path and passively observes the host's eight-channel DMA register writes. For each channel it keeps a copy of the 24-bit source address and the 16-bit byte count. The writes themselves are untouched and still reach the host DMA unit.

When a channel is armed in both the global-enable vector and the per-transfer-enable register, the block compares that channel's recorded source address with each ROM read in the upper banks. The host transfers in fixed-address mode, so the same address repeats for every byte. A read that matches is served from an external streaming decompressor instead of ROM. The first matching read starts the decompressor at that address. Each matching read pulls one byte and counts the channel's size down. When the count reaches zero, the block disarms the channel. Reads that do not match pass through to the ROM data.

All read-path outputs are combinational in the cycle of the read request. Channel state, the stream-ready flag and the per-transfer-enable register change on the following clock edge.

Top module: `dma_stream_gate`

## Requirements
- R1: A snoop write is recorded only when address bit 22 is 0 (banks 00-3F and 80-BF) and address bits [15:7] equal 0x086 (offsets 4300-437F). The channel is bits [6:4] and the register is bits [3:0]. All other writes leave every channel unchanged.
- R2: Register 2, 3 and 4 load bits [7:0], [15:8] and [23:16] of the channel address. Register 5 and 6 load bits [7:0] and [15:8] of the channel size. Any other register index changes nothing.
- R3: Reset clears every channel address and size, clears the stream-ready flag and clears the per-transfer-enable register. After reset no read is served from the stream.
- R4: Channel n qualifies for a read only when rd_req_i is high, read address bits [23:22] are 11, bit n of glob_en_i and bit n of xfer_en_o are both set, and the recorded address equals the read address.
- R5: On a qualifying read while the ready flag is clear, dec_start_o pulses in that cycle with dec_start_addr_o equal to the read address, and the flag is then set. Later qualifying reads do not pulse dec_start_o.
- R6: When several channels qualify, the lowest-numbered channel supplies the byte, and only its size and enable bit are affected.
- R7: Each qualifying read drives rd_sel_stream_o and dec_next_o high for that cycle, returns dec_data_i on rd_data_o and decrements the channel size. A read that takes the size from 1 to 0 clears the ready flag and bit n of xfer_en_o.
- R8: A read with no qualifying channel drives rd_sel_stream_o and dec_next_o low and returns rom_data_i on rd_data_o.
- R9: A recorded size of 0 wraps on its first decrement, so the channel serves 65536 bytes before it is disarmed.
- R10: A write on xfer_we_i loads xfer_wdata_i into the per-transfer-enable register. In the same cycle, a completing transfer's clear of its own bit takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| snoop_we_i | input | 1 | Host register write strobe |
| snoop_addr_i | input | 24 | Host register write address |
| snoop_wdata_i | input | 8 | Host register write data |
| rd_req_i | input | 1 | ROM read request |
| rd_addr_i | input | 24 | ROM read address |
| rom_data_i | input | 8 | Bank-mapped ROM data (fallback) |
| glob_en_i | input | 8 | Global per-channel decompression enable |
| xfer_we_i | input | 1 | Load strobe for per-transfer-enable register |
| xfer_wdata_i | input | 8 | Load value for per-transfer-enable register |
| xfer_en_o | output | 8 | Per-transfer-enable register |
| dec_start_o | output | 1 | Decompressor start pulse |
| dec_start_addr_o | output | 24 | Decompressor start address |
| dec_next_o | output | 1 | Next-byte request to decompressor |
| dec_data_i | input | 8 | Decompressed byte, valid while dec_next_o is high |
| rd_sel_stream_o | output | 1 | High when rd_data_o is stream data |
| rd_data_o | output | 8 | Read data returned to the CPU |

## Verification
The read-path results (rd_sel_stream_o, rd_data_o, dec_next_o, dec_start_o and dec_start_addr_o) are due in the same cycle as the request. The bench drives each request on a falling edge and samples these outputs one time unit later, before the next rising edge. Recorded addresses, sizes, the ready flag and xfer_en_o take effect at the rising edge after the write or read. Their effects are therefore checked on the next read or on xfer_en_o after that edge. The size-0 wrap case streams one read per cycle across all 65536 bytes and checks that the channel stays armed until the last byte.

// File: rtl/dsg_pkg.sv
package dsg_pkg;
  localparam int unsigned DSG_ADDR_W = 24;
  localparam int unsigned DSG_DATA_W = 8;
  localparam int unsigned DSG_SIZE_W = 16;
  localparam int unsigned DSG_NUM_CH = 8;
  // register indices inside a channel's 16-byte slot
  localparam logic [3:0] DSG_REG_ADDR0 = 4'd2;
  localparam logic [3:0] DSG_REG_SIZE0 = 4'd5;
  // window 0x4300-0x437F, compared on bits [15:7]
  localparam logic [8:0] DSG_WIN_HI = 9'h086;
endpackage

// File: rtl/dsg_snoop.sv
module dsg_snoop
  import dsg_pkg::*;
#(
  parameter int unsigned NUM_CH = DSG_NUM_CH,
  parameter int unsigned ADDR_W = DSG_ADDR_W,
  parameter int unsigned SIZE_W = DSG_SIZE_W,
  localparam int unsigned CH_W = $clog2(NUM_CH),
  localparam int unsigned ADDR_BYTES = ADDR_W / 8,
  localparam int unsigned SIZE_BYTES = SIZE_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [23:0]       waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic              dec_en_i,
  input  logic [CH_W-1:0]   dec_ch_i,
  output logic [ADDR_W-1:0] chan_addr_o [NUM_CH],
  output logic [SIZE_W-1:0] chan_size_o [NUM_CH]
);
  logic            win_hit;
  logic [CH_W-1:0] wch;
  logic [3:0]      wreg;

  assign win_hit = we_i && !waddr_i[22] && (waddr_i[15:7] == DSG_WIN_HI);
  assign wch     = waddr_i[4 +: CH_W];
  assign wreg    = waddr_i[3:0];

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic ch_wr;
    logic size_wr;
    assign ch_wr   = win_hit && (wch == CH_W'(n));
    assign size_wr = ch_wr && (wreg >= DSG_REG_SIZE0) &&
                     (wreg < DSG_REG_SIZE0 + 4'(SIZE_BYTES));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chan_addr_o[n] <= '0;
      end else if (ch_wr) begin
        for (int k = 0; k < ADDR_BYTES; k++)
          if (wreg == DSG_REG_ADDR0 + 4'(k)) chan_addr_o[n][8*k +: 8] <= wdata_i;
      end
    end

    // a snooped size write wins over a decrement in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chan_size_o[n] <= '0;
      end else if (size_wr) begin
        for (int k = 0; k < SIZE_BYTES; k++)
          if (wreg == DSG_REG_SIZE0 + 4'(k)) chan_size_o[n][8*k +: 8] <= wdata_i;
      end else if (dec_en_i && dec_ch_i == CH_W'(n)) begin
        chan_size_o[n] <= chan_size_o[n] - SIZE_W'(1);
      end
    end
  end
endmodule

// File: rtl/dsg_match.sv
module dsg_match
  import dsg_pkg::*;
#(
  parameter int unsigned NUM_CH = DSG_NUM_CH,
  parameter int unsigned ADDR_W = DSG_ADDR_W,
  localparam int unsigned CH_W = $clog2(NUM_CH)
) (
  input  logic              rd_req_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [NUM_CH-1:0] glob_en_i,
  input  logic [NUM_CH-1:0] xfer_en_i,
  input  logic [ADDR_W-1:0] chan_addr_i [NUM_CH],
  output logic              hit_o,
  output logic [CH_W-1:0]   hit_ch_o
);
  logic              upper;
  logic [NUM_CH-1:0] qual;

  assign upper = rd_req_i && (&rd_addr_i[ADDR_W-1 -: 2]);

  for (genvar n = 0; n < NUM_CH; n++) begin : g_q
    assign qual[n] = upper && glob_en_i[n] && xfer_en_i[n] &&
                     (chan_addr_i[n] == rd_addr_i);
  end

  // descending scan: lowest qualifying channel is the last one written
  always_comb begin
    hit_ch_o = '0;
    for (int n = NUM_CH - 1; n >= 0; n--)
      if (qual[n]) hit_ch_o = CH_W'(n);
  end

  assign hit_o = |qual;
endmodule

// File: rtl/dsg_ctrl.sv
module dsg_ctrl
  import dsg_pkg::*;
#(
  parameter int unsigned NUM_CH = DSG_NUM_CH,
  parameter int unsigned SIZE_W = DSG_SIZE_W,
  localparam int unsigned CH_W = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic [CH_W-1:0]   hit_ch_i,
  input  logic [SIZE_W-1:0] hit_size_i,
  input  logic              xfer_we_i,
  input  logic [NUM_CH-1:0] xfer_wdata_i,
  output logic [NUM_CH-1:0] xfer_en_o,
  output logic              ready_o,
  output logic              last_o,
  output logic              start_o
);
  logic [NUM_CH-1:0] clr_mask;
  logic [NUM_CH-1:0] xfer_base;

  assign last_o   = (hit_size_i == SIZE_W'(1));
  assign start_o  = hit_i && !ready_o;
  assign clr_mask = (hit_i && last_o) ? (NUM_CH'(1) << hit_ch_i) : '0;
  assign xfer_base = xfer_we_i ? xfer_wdata_i : xfer_en_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_o   <= 1'b0;
      xfer_en_o <= '0;
    end else begin
      xfer_en_o <= xfer_base & ~clr_mask;
      if (hit_i) ready_o <= !last_o;
    end
  end
endmodule

// File: rtl/dma_stream_gate.sv
module dma_stream_gate
  import dsg_pkg::*;
#(
  parameter int unsigned NUM_CH = DSG_NUM_CH,
  parameter int unsigned ADDR_W = DSG_ADDR_W,
  parameter int unsigned DATA_W = DSG_DATA_W,
  parameter int unsigned SIZE_W = DSG_SIZE_W,
  localparam int unsigned CH_W = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              snoop_we_i,
  input  logic [23:0]       snoop_addr_i,
  input  logic [7:0]        snoop_wdata_i,
  input  logic              rd_req_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] rom_data_i,
  input  logic [NUM_CH-1:0] glob_en_i,
  input  logic              xfer_we_i,
  input  logic [NUM_CH-1:0] xfer_wdata_i,
  output logic [NUM_CH-1:0] xfer_en_o,
  output logic              dec_start_o,
  output logic [ADDR_W-1:0] dec_start_addr_o,
  output logic              dec_next_o,
  input  logic [DATA_W-1:0] dec_data_i,
  output logic              rd_sel_stream_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [ADDR_W-1:0] chan_addr [NUM_CH];
  logic [SIZE_W-1:0] chan_size [NUM_CH];
  logic              hit;
  logic [CH_W-1:0]   hit_ch;
  logic              ready;
  logic              last;

  dsg_snoop #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) i_snoop (
    .clk_i, .rst_ni,
    .we_i       (snoop_we_i),
    .waddr_i    (snoop_addr_i),
    .wdata_i    (snoop_wdata_i),
    .dec_en_i   (hit),
    .dec_ch_i   (hit_ch),
    .chan_addr_o(chan_addr),
    .chan_size_o(chan_size)
  );

  dsg_match #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_match (
    .rd_req_i,
    .rd_addr_i,
    .glob_en_i,
    .xfer_en_i  (xfer_en_o),
    .chan_addr_i(chan_addr),
    .hit_o      (hit),
    .hit_ch_o   (hit_ch)
  );

  dsg_ctrl #(.NUM_CH(NUM_CH), .SIZE_W(SIZE_W)) i_ctrl (
    .clk_i, .rst_ni,
    .hit_i       (hit),
    .hit_ch_i    (hit_ch),
    .hit_size_i  (chan_size[hit_ch]),
    .xfer_we_i,
    .xfer_wdata_i,
    .xfer_en_o,
    .ready_o     (ready),
    .last_o      (last),
    .start_o     (dec_start_o)
  );

  assign dec_start_addr_o = rd_addr_i;
  assign dec_next_o       = hit;
  assign rd_sel_stream_o  = hit;
  assign rd_data_o        = hit ? dec_data_i : rom_data_i;
endmodule

// File: rtl/dsg_checker.sv
module dsg_checker #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned ADDR_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_req_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [NUM_CH-1:0] glob_en_i,
  input logic              xfer_we_i,
  input logic [NUM_CH-1:0] xfer_en_o,
  input logic              dec_start_o,
  input logic              dec_next_o,
  input logic              rd_sel_stream_o,
  input logic              ready,
  input logic              last
);
  AST_STREAM_IN_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_sel_stream_o |-> (rd_req_i && (&rd_addr_i[ADDR_W-1 -: 2]))); // R4
  AST_STREAM_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_sel_stream_o |-> ($countones(glob_en_i & xfer_en_o) != 0)); // R4
  AST_START_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_start_o |-> (!ready && dec_next_o)); // R5
  AST_READY_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_start_o && !last) |=> ready); // R5
  AST_DONE_DROPS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sel_stream_o && last) |=> !ready); // R7
  AST_XFER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xfer_we_i && !(rd_sel_stream_o && last)) |=> (xfer_en_o == $past(xfer_en_o))); // R7
  AST_XFER_CLEAR_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xfer_we_i && rd_sel_stream_o && last) |=>
      ($countones($past(xfer_en_o) & ~xfer_en_o) == 1)); // R6
endmodule

bind dma_stream_gate dsg_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_dsg_checker (
  .clk_i, .rst_ni, .rd_req_i, .rd_addr_i, .glob_en_i, .xfer_we_i, .xfer_en_o,
  .dec_start_o, .dec_next_o, .rd_sel_stream_o, .ready, .last
);

// File: tb/test_dma_stream_gate.sv
module test_dma_stream_gate;
  localparam int unsigned CLK_PERIOD = 10;
  localparam logic [7:0]  ROM_VAL = 8'hA5;
  localparam logic [7:0]  DEC_VAL = 8'h5A;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        snoop_we_i = 1'b0;
  logic [23:0] snoop_addr_i = '0;
  logic [7:0]  snoop_wdata_i = '0;
  logic        rd_req_i = 1'b0;
  logic [23:0] rd_addr_i = '0;
  logic [7:0]  glob_en_i = '0;
  logic        xfer_we_i = 1'b0;
  logic [7:0]  xfer_wdata_i = '0;
  logic [7:0]  xfer_en_o;
  logic        dec_start_o;
  logic [23:0] dec_start_addr_o;
  logic        dec_next_o;
  logic        rd_sel_stream_o;
  logic [7:0]  rd_data_o;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  dma_stream_gate i_dma_stream_gate (
    .clk_i, .rst_ni, .snoop_we_i, .snoop_addr_i, .snoop_wdata_i,
    .rd_req_i, .rd_addr_i, .rom_data_i(ROM_VAL), .glob_en_i,
    .xfer_we_i, .xfer_wdata_i, .xfer_en_o, .dec_start_o, .dec_start_addr_o,
    .dec_next_o, .dec_data_i(DEC_VAL), .rd_sel_stream_o, .rd_data_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic snoop(input logic [7:0] bank, input logic [15:0] off, input logic [7:0] d);
    @(negedge clk_i);
    snoop_we_i = 1'b1; snoop_addr_i = {bank, off}; snoop_wdata_i = d;
    @(negedge clk_i);
    snoop_we_i = 1'b0;
  endtask

  task automatic program_ch(input logic [7:0] bank, input int ch,
                            input logic [23:0] a, input logic [15:0] sz);
    logic [15:0] base;
    base = 16'h4300 | 16'(ch << 4);
    snoop(bank, base | 16'd2, a[7:0]);
    snoop(bank, base | 16'd3, a[15:8]);
    snoop(bank, base | 16'd4, a[23:16]);
    snoop(bank, base | 16'd5, sz[7:0]);
    snoop(bank, base | 16'd6, sz[15:8]);
  endtask

  task automatic set_xfer(input logic [7:0] v);
    @(negedge clk_i);
    xfer_we_i = 1'b1; xfer_wdata_i = v;
    @(negedge clk_i);
    xfer_we_i = 1'b0;
  endtask

  // one read: outputs sampled in the request cycle, state updates at the next edge
  task automatic rd(input logic [23:0] a, output logic sel, output logic start,
                    output logic nxt, output logic [7:0] d, output logic [23:0] sa);
    @(negedge clk_i);
    rd_req_i = 1'b1; rd_addr_i = a;
    #1;
    sel = rd_sel_stream_o; start = dec_start_o; nxt = dec_next_o;
    d = rd_data_o; sa = dec_start_addr_o;
    @(negedge clk_i);
    rd_req_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic s, st, nx;
    logic [7:0] d;
    logic [23:0] sa;

    repeat (3) @(negedge clk_i);
    #1;
    check("R3 xfer after reset", 32'(xfer_en_o), 32'h0);
    rst_ni = 1'b1;
    glob_en_i = 8'hFF;
    set_xfer(8'hFF);
    // all addresses and sizes are zero; an upper read of address 0 cannot match bank C0+
    rd(24'hC00000, s, st, nx, d, sa);
    check("R3 no stream after reset", {30'(0), s, st}, 32'h0);
    set_xfer(8'hA5);
    check("R10 xfer load", 32'(xfer_en_o), 32'hA5);

    // sweep every channel, size ch+1, alternating mirror banks
    for (int ch = 0; ch < 8; ch++) begin
      logic [23:0] a;
      a = 24'hC01234 | 24'(ch << 18) | 24'(ch);
      program_ch((ch % 2) ? 8'h80 : 8'h00, ch, a, 16'(ch + 1));
      set_xfer(8'(1 << ch));
      for (int i = 0; i <= ch; i++) begin
        rd(a, s, st, nx, d, sa);
        check("R7 stream sel/next", {30'(0), s, nx}, 32'h3);
        check("R7 stream data", 32'(d), 32'(DEC_VAL));
        check("R5 start only first", 32'(st), (i == 0) ? 32'h1 : 32'h0);
        if (i == 0) check("R5 start address", 32'(sa), 32'(a));
        if (i < ch) check("R7 enable held", 32'(xfer_en_o), 32'(1 << ch));
      end
      check("R7 enable cleared at zero", 32'(xfer_en_o), 32'h0);
      rd(a, s, st, nx, d, sa);
      check("R8 fallback sel/next", {30'(0), s, nx}, 32'h0);
      check("R8 fallback data", 32'(d), 32'(ROM_VAL));
    end

    // R4: global enable gates the channel
    program_ch(8'h00, 3, 24'hF0ABCD, 16'd2);
    set_xfer(8'h08);
    glob_en_i = 8'hF7;
    rd(24'hF0ABCD, s, st, nx, d, sa);
    check("R4 global enable gates", {30'(0), s, nx}, 32'h0);
    glob_en_i = 8'hFF;
    rd(24'hF0ABCD, s, st, nx, d, sa);
    check("R4 enabled matches", 32'(s), 32'h1);
    rd(24'hF0ABCE, s, st, nx, d, sa);
    check("R4 address mismatch", 32'(s), 32'h0);

    // R4: lower bank never substitutes
    program_ch(8'h00, 4, 24'h7F1234, 16'd2);
    set_xfer(8'h10);
    rd(24'h7F1234, s, st, nx, d, sa);
    check("R4 lower bank ignored", {30'(0), s, nx}, 32'h0);

    // R1/R2: out-of-window and unused-register writes leave ch0 intact
    program_ch(8'h00, 0, 24'hC40010, 16'd3);
    snoop(8'h40, 16'h4302, 8'hFF);
    snoop(8'hC0, 16'h4302, 8'hFF);
    snoop(8'h00, 16'h4382, 8'hFF);
    snoop(8'h00, 16'h4402, 8'hFF);
    snoop(8'h00, 16'h4307, 8'hFF);
    snoop(8'h00, 16'h4300, 8'hFF);
    set_xfer(8'h01);
    rd(24'hC40010, s, st, nx, d, sa);
    check("R1 ignored writes kept address", 32'(s), 32'h1);
    rd(24'hC40010, s, st, nx, d, sa);
    rd(24'hC40010, s, st, nx, d, sa);
    check("R2 size kept at three", 32'(xfer_en_o), 32'h0);

    // R6: priority between ch2 and ch5 on the same address
    program_ch(8'h80, 2, 24'hD00042, 16'd1);
    program_ch(8'h00, 5, 24'hD00042, 16'd1);
    set_xfer(8'h24);
    rd(24'hD00042, s, st, nx, d, sa);
    check("R6 first read stream", {30'(0), s, st}, 32'h3);
    check("R6 lowest channel consumed", 32'(xfer_en_o), 32'h20);
    rd(24'hD00042, s, st, nx, d, sa);
    check("R6 next channel restarts", {30'(0), s, st}, 32'h3);
    check("R6 both consumed", 32'(xfer_en_o), 32'h0);

    // R9: size 0 streams 65536 bytes, one read per cycle
    program_ch(8'h00, 7, 24'hE00000, 16'd0);
    set_xfer(8'h80);
    begin
      int miss;
      miss = 0;
      @(negedge clk_i);
      rd_req_i = 1'b1; rd_addr_i = 24'hE00000;
      for (int i = 0; i < 65536; i++) begin
        #1;
        if (!rd_sel_stream_o || (i > 0 && xfer_en_o !== 8'h80)) miss++;
        @(negedge clk_i);
      end
      rd_req_i = 1'b0;
      check("R9 65536 bytes streamed", 32'(miss), 32'h0);
      #1;
      check("R9 disarmed after wrap run", 32'(xfer_en_o), 32'h0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule